// File: doc/BRIEF.md
# Egress VLAN Tag Editor

This block sits on the byte stream of one egress port, between the frame buffer and the MAC. For each frame it picks one of three edits. It can insert a 4-byte 802.1Q tag after the two MAC addresses, delete the tag found at that position, or leave the body as it is. The frame check sequence that arrives with the frame is always discarded, and a fresh CRC-32 over the outgoing bytes is appended. Every outgoing frame therefore carries a correct FCS, whichever edit it received.

Both stream sides are byte-wide valid/ready with first-byte and last-byte markers. Two sideband inputs travel with the frame and are read on its first byte: the ingress port number and a flag saying the frame already carries a tag. The configuration inputs are also read on the first byte:
- an insert enable and a remove enable for this egress port;
- a mask with one bit per ingress port, which allows insertion for frames from that port;
- one 16-bit default tag control word per ingress port.

Frames are at least 20 bytes long, FCS included. Padding of short frames and any buffering beyond the four-byte FCS delay belong elsewhere.

Top module: `vlan_tag_editor`

## Requirements
- R1: An untagged frame is modified when three conditions hold on its first byte: ins_en_i is 1, bit s of ins_src_mask_i is 1, and in_src_i is s. The frame then receives bytes 0x81, 0x00, def_tci_i[16s+15:16s+8] and def_tci_i[16s+7:16s] as output bytes 12 to 15. The input bytes from byte 12 onward follow them.
- R2: An untagged frame whose source mask bit is 0, or which arrives while ins_en_i is 0, leaves with its body (all input bytes except the last four) unchanged.
- R3: A frame flagged tagged by in_tagged_i while rem_en_i is 0 is never given a second tag, even with insertion enabled. Its body leaves unchanged.
- R4: A frame flagged tagged while rem_en_i is 1 leaves without input bytes 12 to 15. All other body bytes keep their order.
- R5: An untagged frame that arrives while only rem_en_i is 1 leaves with its body unchanged.
- R6: The last four input bytes of every frame are dropped. They are replaced by a CRC-32 computed over all outgoing body bytes, sent least significant byte first. The CRC is reflected, uses polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end. The appended value is the final XORed result.
- R7: While the four tag bytes of an inserting frame go out, in_ready_o stays low. Exactly four cycles in which out_ready_i is 1 pass with the input stalled.
- R8: While input bytes 12 to 15 of a tag-removing frame are accepted, out_valid_o stays low. out_valid_o is also low while the first four bytes of any frame fill the FCS delay.
- R9: out_sof_o is 1 only on the first output byte and out_eof_o only on the last CRC byte. The output length is the input length, plus 4 when inserting and minus 4 when removing.
- R10: No input byte is accepted from the acceptance of a frame's last input byte until its last CRC byte has been accepted downstream.
- R11: While out_valid_o is 1 and out_ready_i is 0, the output byte and out_valid_o hold into the next cycle. This holds provided the upstream keeps a presented byte steady until it is accepted.
- R12: After reset, out_valid_o is 0. With no frame in progress, in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted when high together with valid |
| in_data_i | input | 8 | Input byte |
| in_sof_i | input | 1 | Marks the first input byte of a frame |
| in_eof_i | input | 1 | Marks the last input byte (last FCS byte) |
| in_src_i | input | PORT_W | Ingress port of the frame, read on the first byte |
| in_tagged_i | input | 1 | Frame already carries an 802.1Q tag, read on the first byte |
| ins_en_i | input | 1 | Tag insertion enabled on this egress port |
| rem_en_i | input | 1 | Tag removal enabled on this egress port |
| ins_src_mask_i | input | NUM_PORTS | Per ingress port permission to insert |
| def_tci_i | input | 16*NUM_PORTS | Default tag control word per ingress port, port p at bits 16p+15:16p |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_sof_o | output | 1 | Marks the first output byte |
| out_eof_o | output | 1 | Marks the last output byte (last CRC byte) |

## Verification
The hardest case to reach from the ports is an edit window that meets downstream backpressure. This happens when tag bytes are being emitted, or when the four dropped bytes are skipped, while out_ready_i toggles. Stall and gap counts must then still come out at exactly four. The stimulus sweeps every combination of source port, tag flag, both enables and the full source mask twice: first with a ready sink, then with a pseudo-random one that is low about a quarter of the time. Frame lengths vary from 20 to 60 bytes. Each output frame is compared with an image rebuilt arithmetically in the bench. The bench also confirms that the CRC residue over body and appended FCS comes out at the fixed CRC-32 constant.

// File: rtl/vlan_edit_pkg.sv
package vlan_edit_pkg;
  localparam int unsigned ADDR_BYTES = 12;
  localparam int unsigned TAG_BYTES  = 4;
  localparam int unsigned FCS_BYTES  = 4;
  localparam logic [15:0] TPID       = 16'h8100;
  localparam logic [31:0] CRC_POLY   = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT   = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_INS  = 2'd1,
    MODE_REM  = 2'd2
  } edit_mode_e;

  typedef enum logic [1:0] {
    ST_BODY = 2'd0,
    ST_TAG  = 2'd1,
    ST_FCS  = 2'd2
  } edit_state_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] din);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      c = (c[0] ^ din[i]) ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/vte_mode_sel.sv
module vte_mode_sel
  import vlan_edit_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                    tagged_i,
  input  logic [PORT_W-1:0]       src_i,
  input  logic                    ins_en_i,
  input  logic                    rem_en_i,
  input  logic [NUM_PORTS-1:0]    sel_mask_i,
  input  logic [NUM_PORTS*16-1:0] def_tag_i,
  output edit_mode_e              mode_o,
  output logic [15:0]             tci_o
);
  logic src_ok;

  always_comb begin
    src_ok = 1'b0;
    tci_o  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (src_i == PORT_W'(p)) begin
        src_ok = sel_mask_i[p];
        tci_o  = def_tag_i[p*16 +: 16];
      end
    end
    if (tagged_i) mode_o = rem_en_i ? MODE_REM : MODE_PASS;
    else          mode_o = (ins_en_i && src_ok) ? MODE_INS : MODE_PASS;
  end
endmodule

// File: rtl/vte_fcs_dly.sv
module vte_fcs_dly #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       flush_i,
  input  logic [7:0] data_i,
  output logic       full_o,
  output logic [7:0] head_o
);
  logic [DEPTH-1:0][7:0] stage_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (push_i) stage_q <= {stage_q[DEPTH-2:0], data_i};
      if (flush_i) cnt_q <= '0;
      else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CNT_W'(DEPTH));
  assign head_o = stage_q[DEPTH-1];
endmodule

// File: rtl/vte_crc_acc.sv
module vte_crc_acc
  import vlan_edit_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= CRC_INIT;
    else if (clr_i)  crc_o <= CRC_INIT;
    else if (upd_i)  crc_o <= crc32_step(crc_o, data_i);
  end
endmodule

// File: rtl/vlan_tag_editor.sv
module vlan_tag_editor
  import vlan_edit_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  localparam int unsigned PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [7:0]              in_data_i,
  input  logic                    in_sof_i,
  input  logic                    in_eof_i,
  input  logic [PORT_W-1:0]       in_src_i,
  input  logic                    in_tagged_i,
  input  logic                    ins_en_i,
  input  logic                    rem_en_i,
  input  logic [NUM_PORTS-1:0]    ins_src_mask_i,
  input  logic [NUM_PORTS*16-1:0] def_tci_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [7:0]              out_data_o,
  output logic                    out_sof_o,
  output logic                    out_eof_o
);
  localparam int unsigned IDX_W    = $clog2(ADDR_BYTES + TAG_BYTES + 1);
  localparam int unsigned OIDX_W   = $clog2(ADDR_BYTES + 1);
  localparam logic [IDX_W-1:0]  IDX_SAT  = IDX_W'(ADDR_BYTES + TAG_BYTES);
  localparam logic [IDX_W-1:0]  IDX_CUT  = IDX_W'(ADDR_BYTES);
  localparam logic [OIDX_W-1:0] OIDX_SAT = OIDX_W'(ADDR_BYTES);

  edit_state_e       state_q;
  edit_mode_e        mode_q, mode_new;
  logic [15:0]       tci_q, tci_new;
  logic [IDX_W-1:0]  in_idx_q;
  logic [OIDX_W-1:0] out_idx_q;
  logic [1:0]        sub_q;

  logic        dly_push, dly_full;
  logic [7:0]  dly_head;
  logic [31:0] crc_val, tag_word, fcs_word;
  logic [7:0]  tag_byte, fcs_byte;
  logic        in_fire, out_fire, drop_byte, crc_clr, crc_upd;

  vte_mode_sel #(.NUM_PORTS(NUM_PORTS)) u_mode_sel (
    .tagged_i   (in_tagged_i),
    .src_i      (in_src_i),
    .ins_en_i   (ins_en_i),
    .rem_en_i   (rem_en_i),
    .sel_mask_i (ins_src_mask_i),
    .def_tag_i  (def_tci_i),
    .mode_o     (mode_new),
    .tci_o      (tci_new)
  );

  vte_fcs_dly #(.DEPTH(FCS_BYTES)) u_fcs_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (dly_push),
    .flush_i (in_fire && in_eof_i),
    .data_i  (in_data_i),
    .full_o  (dly_full),
    .head_o  (dly_head)
  );

  vte_crc_acc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .upd_i  (crc_upd),
    .data_i (out_data_o),
    .crc_o  (crc_val)
  );

  assign tag_word  = {TPID, tci_q};
  assign fcs_word  = ~crc_val;
  assign tag_byte  = tag_word[{~sub_q, 3'b000} +: 8];
  assign fcs_byte  = fcs_word[{sub_q, 3'b000} +: 8];
  // input bytes 12..15 of a removing frame are swallowed
  assign drop_byte = (mode_q == MODE_REM) && (in_idx_q >= IDX_CUT) && (in_idx_q < IDX_SAT);

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = dly_head;
    out_sof_o   = 1'b0;
    out_eof_o   = 1'b0;
    dly_push    = 1'b0;
    unique case (state_q)
      ST_BODY: begin
        if (drop_byte) begin
          in_ready_o = 1'b1;
        end else if (!dly_full) begin
          in_ready_o = 1'b1;
          dly_push   = in_valid_i;
        end else begin
          in_ready_o  = out_ready_i;
          out_valid_o = in_valid_i;
          out_sof_o   = in_valid_i && (out_idx_q == '0);
          dly_push    = in_valid_i && out_ready_i;
        end
      end
      ST_TAG: begin
        out_valid_o = 1'b1;
        out_data_o  = tag_byte;
      end
      ST_FCS: begin
        out_valid_o = 1'b1;
        out_data_o  = fcs_byte;
        out_eof_o   = (sub_q == 2'd3);
      end
      default: ;
    endcase
  end

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;
  assign crc_upd  = out_fire && (state_q != ST_FCS);
  assign crc_clr  = out_fire && (state_q == ST_FCS) && (sub_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BODY;
      mode_q    <= MODE_PASS;
      tci_q     <= '0;
      in_idx_q  <= '0;
      out_idx_q <= '0;
      sub_q     <= '0;
    end else begin
      if (in_fire) begin
        if (in_sof_i) begin
          mode_q <= mode_new;
          tci_q  <= tci_new;
        end
        if (in_eof_i) in_idx_q <= '0;
        else if (in_idx_q != IDX_SAT) in_idx_q <= in_idx_q + 1'b1;
      end
      unique case (state_q)
        ST_BODY: begin
          if (out_fire) begin
            if (out_idx_q != OIDX_SAT) out_idx_q <= out_idx_q + 1'b1;
            if (mode_q == MODE_INS && out_idx_q == OIDX_SAT - 1'b1) begin
              state_q <= ST_TAG;
              sub_q   <= '0;
            end
          end
          if (in_fire && in_eof_i) begin
            state_q <= ST_FCS;
            sub_q   <= '0;
          end
        end
        ST_TAG: if (out_fire) begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 2'd3) state_q <= ST_BODY;
        end
        ST_FCS: if (out_fire) begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 2'd3) begin
            state_q   <= ST_BODY;
            out_idx_q <= '0;
          end
        end
        default: state_q <= ST_BODY;
      endcase
    end
  end
endmodule

// File: rtl/vte_checker.sv
module vte_checker
  import vlan_edit_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       in_eof_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_sof_o,
  input logic       out_eof_o,
  input edit_mode_e mode_q
);
  logic        in_fire, out_fire, pend;
  logic [15:0] icnt, ocnt, in_len, exp_len;

  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;
  assign exp_len  = (mode_q == MODE_INS) ? in_len + 16'd4 :
                    (mode_q == MODE_REM) ? in_len - 16'd4 : in_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icnt <= '0; ocnt <= '0; in_len <= '0; pend <= 1'b0;
    end else begin
      if (in_fire) begin
        if (in_eof_i) begin
          in_len <= icnt + 16'd1;
          icnt   <= '0;
          pend   <= 1'b1;
        end else icnt <= icnt + 16'd1;
      end
      if (out_fire) begin
        if (out_eof_o) begin
          ocnt <= '0;
          pend <= 1'b0;
        end else ocnt <= ocnt + 16'd1;
      end
    end
  end

  p_tpid_hi_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && mode_q == MODE_INS && ocnt == 16'(ADDR_BYTES) |-> out_data_o == 8'h81);
  p_tpid_lo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && mode_q == MODE_INS && ocnt == 16'(ADDR_BYTES + 1) |-> out_data_o == 8'h00);
  p_ins_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && mode_q == MODE_INS && ocnt >= 16'(ADDR_BYTES) && ocnt < 16'(ADDR_BYTES + TAG_BYTES)
    |-> !in_ready_o);
  p_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_eof_o |-> (ocnt + 16'd1) == exp_len);
  p_sof_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire && out_sof_o |-> ocnt == '0);
  p_fcs_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> !in_fire);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

bind vlan_tag_editor vte_checker u_vte_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_eof_i    (in_eof_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_sof_o   (out_sof_o),
  .out_eof_o   (out_eof_o),
  .mode_q      (mode_q)
);

// File: tb/vlan_tag_editor_test.sv
module vlan_tag_editor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_tagged = 1'b0;
  logic [7:0]  in_data = '0;
  logic [1:0]  in_src = '0;
  logic        ins_en = 1'b0, rem_en = 1'b0;
  logic [2:0]  mask = '0;
  logic [47:0] tags = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sof, out_eof;
  logic [7:0]  out_data;

  always #4 clk = ~clk;

  vlan_tag_editor #(.NUM_PORTS(3)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_eof_i(in_eof), .in_src_i(in_src), .in_tagged_i(in_tagged),
    .ins_en_i(ins_en), .rem_en_i(rem_en), .ins_src_mask_i(mask), .def_tci_i(tags),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_eof_o(out_eof)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_byte(input logic [31:0] r, input logic [7:0] b);
    logic [31:0] x;
    x = r ^ {24'h0, b};
    repeat (8) x = {1'b0, x[31:1]} ^ (32'hEDB88320 & {32{x[0]}});
    return x;
  endfunction

  logic [7:0] exp_q[$];
  int         exp_len_q[$];
  int         exp_mode_q[$];
  string      exp_req_q[$];

  // out_ready pattern: always high, or pseudo-random (low ~1/4 of cycles)
  bit         rnd_rdy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rnd_rdy ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  task automatic send_frame(input int len, input int seed, input int src, input bit tg,
                            input bit ie, input bit re, input logic [2:0] mk);
    logic [7:0]  fr[$];
    logic [7:0]  ex[$];
    logic [15:0] tci;
    logic [31:0] c;
    int md;
    string rq;
    for (int i = 0; i < len; i++) fr.push_back(8'((i * 29 + seed * 7 + 3) ^ (i >> 2)));
    if (tg) begin fr[12] = 8'h81; fr[13] = 8'h00; end
    tci = tags[src*16 +: 16];
    md = 0;
    if (tg && re) md = 2;
    else if (!tg && ie && mk[src]) md = 1;
    rq = (md == 1) ? "R1" : (md == 2) ? "R4" : tg ? "R3" : (re && !ie) ? "R5" : "R2";
    for (int i = 0; i < len - 4; i++) begin
      if (md == 2 && i >= 12 && i < 16) continue;
      if (md == 1 && i == 12) begin
        ex.push_back(8'h81); ex.push_back(8'h00);
        ex.push_back(tci[15:8]); ex.push_back(tci[7:0]);
      end
      ex.push_back(fr[i]);
    end
    c = 32'hFFFFFFFF;
    foreach (ex[i]) c = crc_byte(c, ex[i]);
    c = ~c;
    for (int k = 0; k < 4; k++) ex.push_back(c[k*8 +: 8]);
    foreach (ex[i]) exp_q.push_back(ex[i]);
    exp_len_q.push_back(ex.size());
    exp_mode_q.push_back(md);
    exp_req_q.push_back(rq);
    ins_en = ie; rem_en = re; mask = mk;
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == len - 1);
      in_src = 2'(src); in_tagged = tg;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // monitor
  int o_pos = 0, o_err = 0, stall_c = 0, gap_c = 0, in_after_eof = 0;
  bit in_act = 0, pend = 0, hold_pend = 0;
  logic [7:0]  hold_d;
  logic [31:0] res;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (hold_pend) chk(out_valid && out_data == hold_d, "R11", "held output byte", out_data, hold_d);
      hold_pend = out_valid && !out_ready;
      hold_d = out_data;
      if (in_act && in_valid && !in_ready && out_ready) stall_c++;
      if (in_valid && in_ready) begin
        if (pend) in_after_eof++;
        if (in_sof) begin in_act = 1; stall_c = 0; gap_c = 0; end
        if (!out_valid) gap_c++;
        if (in_eof) begin
          chk(stall_c == ((exp_mode_q[0] == 1) ? 4 : 0), "R7", "input stall cycles", stall_c,
              (exp_mode_q[0] == 1) ? 4 : 0);
          chk(gap_c == ((exp_mode_q[0] == 2) ? 8 : 4), "R8", "accepts without output", gap_c,
              (exp_mode_q[0] == 2) ? 8 : 4);
          in_act = 0; pend = 1;
        end
      end
      if (out_valid && out_ready) begin
        if (o_pos == 0) begin
          res = 32'hFFFFFFFF; o_err = 0;
          if (!out_sof) o_err++;
        end else if (out_sof) o_err++;
        if (exp_q.size() == 0) o_err++;
        else if (exp_q.pop_front() != out_data) o_err++;
        res = crc_byte(res, out_data);
        o_pos++;
        if (out_eof) begin
          chk(o_err == 0, exp_req_q[0], "mismatching output bytes", o_err, 0);
          chk(o_pos == exp_len_q[0], "R9", "output frame length", o_pos, exp_len_q[0]);
          chk(res == 32'hDEBB20E3, "R6", "CRC residue", res, 32'hDEBB20E3);
          chk(in_after_eof == 0, "R10", "inputs accepted during FCS", in_after_eof, 0);
          void'(exp_len_q.pop_front()); void'(exp_mode_q.pop_front()); void'(exp_req_q.pop_front());
          o_pos = 0; pend = 0; in_after_eof = 0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual %0d frames pending expected 0", exp_len_q.size());
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
    k = 0;
    for (int ph = 0; ph < 2; ph++) begin
      rnd_rdy = (ph == 1);
      tags = (ph == 0) ? {16'hE00C, 16'hA05B, 16'h3FF1} : {16'h1234, 16'hC0DE, 16'h7A05};
      for (int s = 0; s < 3; s++)
        for (int tg = 0; tg < 2; tg++)
          for (int ie = 0; ie < 2; ie++)
            for (int re = 0; re < 2; re++)
              for (int mk = 0; mk < 8; mk++) begin
                send_frame(20 + (k % 41), k, s, tg[0], ie[0], re[0], 3'(mk));
                k++;
              end
    end
    while (exp_len_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule